// File: doc/BRIEF.md
# Sequence-Ordered Frame Reassembler

This block sits at the receive end of a link that spreads a client frame over many parallel lanes as 64-bit blocks. Each block arrives with its own header: a sequence number, a two-bit boundary flag and the total frame length in bytes. Lanes are not deskewed, so blocks can arrive in any order and on any lane. The block stores each incoming block in a small reorder buffer. The buffer slot is chosen by the low bits of the sequence number. Blocks leave the buffer strictly in sequence order.

On the way out, the boundary flags mark where client frames open and close, and the length field trims the last block of each frame to its real byte count. The output is a byte-enabled frame stream with start and end markers.

If a block goes missing, the stream does not stall forever. After a programmable wait, the missing sequence number is skipped, and any frame that was open at that point is closed with an error marker. Blocks that arrive with no frame to belong to are discarded, and those that carry an end flag are counted.

Top module: `seq_frame_reassembler`

## Requirements
- R1: A valid block on any lane is stored only if two conditions hold. First, its sequence number minus the expected sequence number (modulo 2^SEQ_W) must be below 2^IDX_W. Second, the slot addressed by its low IDX_W bits must be empty. Blocks outside that window, or aimed at a full slot, are dropped. When two lanes aim at the same slot in the same cycle, the lower-numbered lane wins.
- R2: Blocks are emitted one per cycle at most, in strictly increasing sequence order. A block is released only when it is the expected one. After each release the expected sequence advances by one and the slot is freed. A block stored at clock edge k is emitted at edge k+1 at the earliest.
- R3: Flag bit 0 marks a frame start and flag bit 1 marks a frame end; both may be set together. A start block is emitted with outSop, and an end block inside a frame is emitted with outEop. A block with neither flag that arrives while no frame is open is discarded without output.
- R4: Byte i of outData is bits 8i+7..8i, and it is valid when outKeep bit i is set. On an end block, let m be the block's length field modulo 8. The lowest m keep bits are set, or all 8 bits if m is 0. Every other emitted block has all 8 keep bits set.
- R5: The expected slot may stay empty while other blocks wait in the buffer. After TIMEOUT consecutive such cycles, the expected sequence skips by one. If a frame was open, one beat is emitted with outErr=1, outEop=1, outSop=0, outKeep=0 and outData=0, and the frame is closed.
- R6: A block with the end flag and no start flag is discarded when it arrives while no frame is open, and errCount increments by one.
- R7: After reset, outValid is 0, errCount is 0 and the expected sequence number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | LANES | Per-lane block valid |
| inSeq | input | LANES*SEQ_W | Per-lane sequence numbers, lane i at bits i*SEQ_W |
| inFlags | input | LANES*2 | Per-lane flags (bit 0 start, bit 1 end) |
| inLen | input | LANES*LEN_W | Per-lane frame length in bytes |
| inData | input | LANES*64 | Per-lane 64-bit payloads |
| outValid | output | 1 | Output beat valid |
| outData | output | 64 | Output payload |
| outKeep | output | 8 | Byte enables |
| outSop | output | 1 | First beat of a frame |
| outEop | output | 1 | Last beat of a frame |
| outErr | output | 1 | Frame aborted by timeout |
| errCount | output | CNT_W | Count of end blocks that had no open frame |

## Verification
The hardest situation to reach from the ports is a timeout that fires while a frame is open. The start block must already have left the buffer, the next sequence number must never arrive, and a later block must sit in the buffer to keep the wait counter running. The stimulus sends the start block and a block two sequence numbers later, then withholds the middle one. It then expects the abort beat, followed by the late end block being counted as orphaned. A second case fills every slot of the window in reverse order, so the whole buffer drains in one burst.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int DATA_W  = 64;
  localparam int BYTES   = DATA_W / 8;
  localparam int FLG_W   = 2;
  localparam int FLG_SOF = 0;
  localparam int FLG_EOF = 1;

  typedef struct packed {
    logic rel;    // expected slot consumed
    logic emit;   // drive a data beat
    logic sop;
    logic eop;
    logic trim;   // apply length trim to keep
    logic abort;  // drive a timeout error beat
  } ctlStrb_t;
endpackage

// File: rtl/srq_ctrl.sv
module srq_ctrl
  import srq_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SEQ_W   = 16,
  parameter int IDX_W   = 3,
  parameter int TIMEOUT = 16,
  parameter int CNT_W   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES-1:0]       inValid,
  input  logic [LANES*SEQ_W-1:0] inSeq,
  input  logic [FLG_W-1:0]       headFlags,
  output logic [LANES-1:0]       laneAcc,
  output logic [IDX_W-1:0]       expIdx,
  output ctlStrb_t               strb,
  output logic [CNT_W-1:0]       errCount
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int TW    = $clog2(TIMEOUT + 1);

  logic [SLOTS-1:0] slotVal;
  logic [SEQ_W-1:0] expSeq;
  logic             inFrame;
  logic [TW-1:0]    waitCnt;

  logic [SEQ_W-1:0] laneDist [LANES];
  logic [IDX_W-1:0] laneIdx  [LANES];
  logic             laneOk   [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      assign laneDist[g] = inSeq[g*SEQ_W +: SEQ_W] - expSeq;
      assign laneIdx[g]  = inSeq[g*SEQ_W +: IDX_W];
      assign laneOk[g]   = inValid[g] && (laneDist[g] < SEQ_W'(SLOTS)) &&
                           !slotVal[laneIdx[g]];
    end
  endgenerate

  // lowest lane wins a shared slot
  always_comb begin
    laneAcc = '0;
    for (int i = 0; i < LANES; i++) begin
      laneAcc[i] = laneOk[i];
      for (int j = 0; j < i; j++)
        if (laneAcc[j] && laneIdx[j] == laneIdx[i]) laneAcc[i] = 1'b0;
    end
  end

  assign expIdx = expSeq[IDX_W-1:0];

  logic headVal, pending, skip, errInc;
  assign headVal = slotVal[expIdx];
  assign pending = |slotVal;

  always_comb begin
    strb   = '0;
    skip   = 1'b0;
    errInc = 1'b0;
    if (headVal) begin
      strb.rel = 1'b1;
      if (headFlags[FLG_SOF] || inFrame) begin
        strb.emit = 1'b1;
        strb.sop  = headFlags[FLG_SOF];
        strb.eop  = headFlags[FLG_EOF];
        strb.trim = headFlags[FLG_EOF];
      end else if (headFlags[FLG_EOF]) begin
        errInc = 1'b1;
      end
    end else if (pending && waitCnt == TW'(TIMEOUT - 1)) begin
      skip       = 1'b1;
      strb.abort = inFrame;
    end
  end

  logic [SLOTS-1:0] setMask, clrMask;
  always_comb begin
    setMask = '0;
    for (int i = 0; i < LANES; i++)
      if (laneAcc[i]) setMask[laneIdx[i]] = 1'b1;
    clrMask = strb.rel ? (SLOTS'(1) << expIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotVal  <= '0;
      expSeq   <= '0;
      inFrame  <= 1'b0;
      waitCnt  <= '0;
      errCount <= '0;
    end else begin
      slotVal <= (slotVal & ~clrMask) | setMask;
      if (strb.rel || skip) expSeq <= expSeq + SEQ_W'(1);
      if (strb.emit)      inFrame <= !strb.eop;
      else if (skip)      inFrame <= 1'b0;
      if (!headVal && pending && !skip) waitCnt <= waitCnt + TW'(1);
      else                              waitCnt <= '0;
      if (errInc) errCount <= errCount + CNT_W'(1);
    end
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(expSeq) |-> expSeq == $past(expSeq) + SEQ_W'(1)); // R2
  AST_SLOT_FREED: assert property (@(posedge clk) disable iff (!rstN)
    strb.rel |=> !slotVal[$past(expIdx)]); // R1
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt < TW'(TIMEOUT)); // R5
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(errCount) |-> errCount == $past(errCount) + CNT_W'(1)); // R6
endmodule

// File: rtl/srq_dpath.sv
module srq_dpath
  import srq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 3,
  parameter int LEN_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES-1:0]        laneAcc,
  input  logic [LANES*SEQ_W-1:0]  inSeq,
  input  logic [LANES*FLG_W-1:0]  inFlags,
  input  logic [LANES*LEN_W-1:0]  inLen,
  input  logic [LANES*DATA_W-1:0] inData,
  input  logic [IDX_W-1:0]        expIdx,
  input  ctlStrb_t                strb,
  output logic [FLG_W-1:0]        headFlags,
  output logic                    outValid,
  output logic [DATA_W-1:0]       outData,
  output logic [BYTES-1:0]        outKeep,
  output logic                    outSop,
  output logic                    outEop,
  output logic                    outErr
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int BW    = $clog2(BYTES);

  logic [DATA_W-1:0] payMem [SLOTS];
  logic [LEN_W-1:0]  lenMem [SLOTS];
  logic [FLG_W-1:0]  flgMem [SLOTS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (laneAcc[i]) begin
        payMem[inSeq[i*SEQ_W +: IDX_W]] <= inData[i*DATA_W +: DATA_W];
        lenMem[inSeq[i*SEQ_W +: IDX_W]] <= inLen[i*LEN_W +: LEN_W];
        flgMem[inSeq[i*SEQ_W +: IDX_W]] <= inFlags[i*FLG_W +: FLG_W];
      end
    end
  end

  assign headFlags = flgMem[expIdx];

  logic [BW-1:0]    tailBytes;
  logic [BYTES-1:0] trimKeep;
  assign tailBytes = lenMem[expIdx][BW-1:0];
  always_comb begin
    for (int b = 0; b < BYTES; b++)
      trimKeep[b] = (tailBytes == '0) || (BW'(b) < tailBytes);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outKeep  <= '0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outErr   <= 1'b0;
    end else begin
      outValid <= strb.emit || strb.abort;
      outData  <= '0;
      outKeep  <= '0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outErr   <= 1'b0;
      if (strb.emit) begin
        outData <= payMem[expIdx];
        outKeep <= strb.trim ? trimKeep : '1;
        outSop  <= strb.sop;
        outEop  <= strb.eop;
      end else if (strb.abort) begin
        outEop <= 1'b1;
        outErr <= 1'b1;
      end
    end
  end

  AST_TRIM_ONLY_EOP: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outKeep != '1 && !outErr |-> outEop); // R4
  AST_ABORT_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outErr |-> outEop && !outSop && outKeep == '0); // R5
endmodule

// File: rtl/seq_frame_reassembler.sv
module seq_frame_reassembler
  import srq_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SEQ_W   = 16,
  parameter int IDX_W   = 3,
  parameter int LEN_W   = 8,
  parameter int TIMEOUT = 16,
  parameter int CNT_W   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES-1:0]        inValid,
  input  logic [LANES*SEQ_W-1:0]  inSeq,
  input  logic [LANES*2-1:0]      inFlags,
  input  logic [LANES*LEN_W-1:0]  inLen,
  input  logic [LANES*64-1:0]     inData,
  output logic                    outValid,
  output logic [63:0]             outData,
  output logic [7:0]              outKeep,
  output logic                    outSop,
  output logic                    outEop,
  output logic                    outErr,
  output logic [CNT_W-1:0]        errCount
);
  ctlStrb_t         strb;
  logic [LANES-1:0] laneAcc;
  logic [IDX_W-1:0] expIdx;
  logic [FLG_W-1:0] headFlags;

  srq_ctrl #(.LANES(LANES), .SEQ_W(SEQ_W), .IDX_W(IDX_W),
             .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSeq(inSeq),
    .headFlags(headFlags), .laneAcc(laneAcc), .expIdx(expIdx),
    .strb(strb), .errCount(errCount));

  srq_dpath #(.LANES(LANES), .SEQ_W(SEQ_W), .IDX_W(IDX_W),
              .LEN_W(LEN_W)) dpath_i (
    .clk(clk), .rstN(rstN), .laneAcc(laneAcc), .inSeq(inSeq),
    .inFlags(inFlags), .inLen(inLen), .inData(inData), .expIdx(expIdx),
    .strb(strb), .headFlags(headFlags), .outValid(outValid),
    .outData(outData), .outKeep(outKeep), .outSop(outSop),
    .outEop(outEop), .outErr(outErr));
endmodule

// File: tb/seq_frame_reassembler_tb_top.sv
module seq_frame_reassembler_tb_top;
  localparam int LANES = 4, SEQ_W = 16, IDX_W = 3, LEN_W = 8;
  localparam int TIMEOUT = 16, CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LANES-1:0]       inValid = '0;
  logic [LANES*SEQ_W-1:0] inSeq = '0;
  logic [LANES*2-1:0]     inFlags = '0;
  logic [LANES*LEN_W-1:0] inLen = '0;
  logic [LANES*64-1:0]    inData = '0;
  logic        outValid, outSop, outEop, outErr;
  logic [63:0] outData;
  logic [7:0]  outKeep;
  logic [CNT_W-1:0] errCount;

  always #10 clk = ~clk;

  seq_frame_reassembler #(.LANES(LANES), .SEQ_W(SEQ_W), .IDX_W(IDX_W),
    .LEN_W(LEN_W), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSeq(inSeq),
    .inFlags(inFlags), .inLen(inLen), .inData(inData),
    .outValid(outValid), .outData(outData), .outKeep(outKeep),
    .outSop(outSop), .outEop(outEop), .outErr(outErr),
    .errCount(errCount));

  typedef struct {
    logic [63:0] data;
    logic [7:0]  keep;
    logic        sop, eop, err;
    string       tag;
  } beat_t;

  beat_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // monitor: pop and compare every output beat
  always @(negedge clk) begin
    if (rstN && outValid && !done) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected beat: actual data=%h keep=%h sop=%b eop=%b err=%b expected none",
                 outData, outKeep, outSop, outEop, outErr);
      end else begin
        beat_t e;
        e = expQ.pop_front();
        if (outData !== e.data || outKeep !== e.keep || outSop !== e.sop ||
            outEop !== e.eop || outErr !== e.err) begin
          errors++;
          $display("FAIL %s: actual data=%h keep=%h sop=%b eop=%b err=%b expected data=%h keep=%h sop=%b eop=%b err=%b",
                   e.tag, outData, outKeep, outSop, outEop, outErr,
                   e.data, e.keep, e.sop, e.eop, e.err);
        end
      end
    end
  end

  task automatic expectBeat(input logic [63:0] d, input logic [7:0] k,
                            input logic s, input logic e, input logic r,
                            input string tag);
    beat_t b;
    b.data = d; b.keep = k; b.sop = s; b.eop = e; b.err = r; b.tag = tag;
    expQ.push_back(b);
  endtask

  task automatic setLane(input int ln, input logic [SEQ_W-1:0] sq,
                         input logic [1:0] fl, input logic [LEN_W-1:0] len,
                         input logic [63:0] d);
    inValid[ln] = 1'b1;
    inSeq[ln*SEQ_W +: SEQ_W] = sq;
    inFlags[ln*2 +: 2] = fl;
    inLen[ln*LEN_W +: LEN_W] = len;
    inData[ln*64 +: 64] = d;
  endtask

  task automatic pulse();
    @(posedge clk);
    @(negedge clk);
    inValid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 reset state
    checkVal("R7 outValid", int'(outValid), 0);
    checkVal("R7 errCount", int'(errCount), 0);

    // R1 R2 R3 R4: three-block frame, out of order across lanes
    expectBeat(64'hA000_0000_0000_0000, 8'hFF, 1, 0, 0, "R3 frame A start");
    expectBeat(64'hA000_0000_0000_0001, 8'hFF, 0, 0, 0, "R2 frame A mid");
    expectBeat(64'hA000_0000_0000_0002, 8'h0F, 0, 1, 0, "R4 frame A end len 20");
    setLane(0, 16'd2, 2'b10, 8'd20, 64'hA000_0000_0000_0002);
    setLane(1, 16'd0, 2'b01, 8'd20, 64'hA000_0000_0000_0000);
    setLane(2, 16'd1, 2'b00, 8'd20, 64'hA000_0000_0000_0001);
    pulse();
    idle(5);

    // R4: single-block frame, length multiple of 8
    expectBeat(64'hB000_0000_0000_0003, 8'hFF, 1, 1, 0, "R4 single len 8");
    setLane(3, 16'd3, 2'b11, 8'd8, 64'hB000_0000_0000_0003);
    pulse();
    idle(4);

    // R1: seq 20 is out of window (exp=4) and aims at seq 4's slot
    setLane(0, 16'd20, 2'b11, 8'd8, 64'hDEAD_0000_0000_0020);
    pulse();
    expectBeat(64'hC000_0000_0000_0004, 8'hFF, 1, 0, 0, "R1 window start");
    expectBeat(64'hC000_0000_0000_0005, 8'h1F, 0, 1, 0, "R4 end len 13");
    setLane(1, 16'd4, 2'b01, 8'd13, 64'hC000_0000_0000_0004);
    setLane(2, 16'd5, 2'b10, 8'd13, 64'hC000_0000_0000_0005);
    pulse();
    idle(5);

    // R1: two lanes same slot, lane 0 wins
    expectBeat(64'hD000_0000_0000_0006, 8'h07, 1, 1, 0, "R1 lane priority");
    setLane(0, 16'd6, 2'b11, 8'd3, 64'hD000_0000_0000_0006);
    setLane(1, 16'd6, 2'b11, 8'd3, 64'hEEEE_0000_0000_0006);
    pulse();
    idle(4);

    // R3: orphan middle block silent; R6: orphan end counted
    setLane(2, 16'd7, 2'b00, 8'd8, 64'hF000_0000_0000_0007);
    setLane(3, 16'd8, 2'b10, 8'd8, 64'hF000_0000_0000_0008);
    pulse();
    idle(5);
    checkVal("R6 errCount after orphan end", int'(errCount), 1);

    // R5: timeout with open frame, then late end block is orphaned (R6)
    expectBeat(64'h1000_0000_0000_0009, 8'hFF, 1, 0, 0, "R5 start before gap");
    expectBeat(64'h0, 8'h00, 0, 1, 1, "R5 abort beat");
    setLane(0, 16'd9, 2'b01, 8'd16, 64'h1000_0000_0000_0009);
    setLane(1, 16'd11, 2'b10, 8'd16, 64'h1000_0000_0000_000B);
    pulse();
    idle(TIMEOUT + 8);
    checkVal("R6 errCount after late end", int'(errCount), 2);

    // R5: timeout with no frame open skips silently
    expectBeat(64'h2000_0000_0000_000D, 8'h1F, 1, 1, 0, "R5 skip without abort");
    setLane(2, 16'd13, 2'b11, 8'd5, 64'h2000_0000_0000_000D);
    pulse();
    idle(TIMEOUT + 8);

    // R2: full window filled in reverse order
    for (int s = 14; s <= 21; s++)
      expectBeat(64'h3000_0000_0000_0000 | 64'(s), (s == 21) ? 8'h1F : 8'hFF,
                 s == 14, s == 21, 0, "R2 full window order");
    for (int s = 21; s >= 14; s--) begin
      setLane(s % LANES, 16'(s), (s == 14) ? 2'b01 : ((s == 21) ? 2'b10 : 2'b00),
              8'd61, 64'h3000_0000_0000_0000 | 64'(s));
      pulse();
    end
    idle(12);

    checkVal("R2 all expected beats seen", expQ.size(), 0);
    checkVal("R6 errCount final", int'(errCount), 2);
    finishRun();
  end
endmodule